// File: doc/BRIEF.md
# Accumulator Scale, Round and Saturate Unit

This unit turns a bank of wide lane accumulators into one packed 64-bit vector. Each accumulator is shifted right by its own amount, rounded by the selected rounding mode and clamped to the lane width. In halfword format there are four 48-bit accumulators that give four 16-bit lanes. In byte format there are eight 24-bit accumulators that give eight 8-bit lanes. Both formats share one 192-bit accumulator bus.

The shift amount can come from three places: the matching lane of a shift vector, one element of that vector broadcast to every lane, or a 5-bit immediate. A request is registered: the packed result and an unpredictable-result flag appear one cycle after `in_valid` and hold until the next request. Some requests have no defined result: a negative halfword shift, a signed mode in byte format, or a reserved mode code. These give zeros in the affected lanes and raise the flag.

Top module: `rsat_unit`

## Requirements
- R1: In reset, `out_valid`, `result` and `unpred` are 0. A request accepted on an edge where `in_valid` is high appears on `result` and `unpred` after that edge, with `out_valid` high for one cycle. While `in_valid` is low, `result` and `unpred` hold their values.
- R2: With `fmt`=1 (halfword), lane i takes `acc_in[48i+47:48i]` and writes `result[16i+15:16i]`. With `fmt`=0 (byte), lane i takes `acc_in[24i+23:24i]` and writes `result[8i+7:8i]`.
- R3: With `src_sel`=0, every lane uses vector element `elem_idx`: bits [1:0] of the index pick a 16-bit element in halfword format, and bits [2:0] pick an 8-bit element in byte format. With `src_sel`=1, lane i uses element i. With `src_sel`=2 or 3, every lane uses `shift_imm`, zero-extended. Halfword shift elements are signed 16-bit values. Byte shift elements are unsigned.
- R4: `rmode` codes: 0 nearest-ties-away signed, 1 nearest-ties-away unsigned, 2 nearest-ties-even signed, 3 nearest-ties-even unsigned, 4 truncate signed, 5 truncate unsigned. Truncation is a plain right shift, arithmetic in the signed modes and logical in the unsigned modes.
- R5: Ties-away adds 1 to the shifted value when bit s-1 of the accumulator is set. For a negative accumulator in a signed mode, it adds 1 only if at least one bit below s-1 is also set.
- R6: Ties-even adds 1 when bit s-1 is set and some lower bit is set. When bit s-1 is set and all lower bits are clear, it adds the LSB of the shifted value.
- R7: A signed result clamps to 32767 when accumulator bit 47 is 0, and to -32768 when bit 47 is 1.
- R8: An unsigned result clamps to 0xFFFF (halfword) or 0xFF (byte).
- R9: A shift larger than the accumulator width gives 0. The signed modes also give 0 for a shift of 48 or more.
- R10: An unsigned shift equal to the accumulator width A gives the following. Ties-away gives bit A-1. Ties-even gives 1 when the accumulator is strictly greater than 2^(A-1), and 0 otherwise. Truncate gives that same comparison in halfword format and 0 in byte format.
- R11: A negative halfword shift forces that lane to 0 and sets `unpred`. The other lanes are unaffected.
- R12: A signed mode (0, 2, 4) in byte format, or `rmode` 6 or 7 in either format, gives an all-zero result and sets `unpred`.
- R13: A shift of 0 applies no rounding increment. The accumulator goes straight to saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 1 | 1 halfword, 0 byte |
| rmode | input | 3 | Rounding mode code |
| src_sel | input | 2 | Shift source: 0 element, 1 vector, 2/3 immediate |
| elem_idx | input | 3 | Element index for broadcast shift |
| shift_imm | input | 5 | Immediate shift |
| shift_vec | input | 64 | Shift vector |
| acc_in | input | 192 | Packed lane accumulators |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Packed rounded lanes |
| unpred | output | 1 | Unpredictable-result flag |

## Verification
A rounding increment and a saturation clamp can land in the same lane in the same cycle. This happens when the shifted value sits one below the lane bound and the discarded bits round it up. The imm-shift sweep builds each accumulator as a lane-dependent multiple of 2^s plus an offset of zero, exactly half, half plus one or half minus one. Large multiples push the increment across the bound. Each lane is compared against a bench model that applies the increment first and then the clamp chosen by the accumulator sign. The same cycle can also mix a negative-shift lane that is forced to zero with rounded neighbour lanes. Vector-source requests are built to do this, and the flag and every lane are judged separately.

// File: rtl/rsat_pkg.sv
`timescale 1ns/1ps
// Shared codes for the scale/round/saturate unit.
// Assumes: mode codes above RM_LAST are reserved.
package rsat_pkg;
    localparam logic       FMT_BYTE   = 1'b0;
    localparam logic       FMT_HALF   = 1'b1;
    localparam logic [1:0] SRC_ELEM   = 2'd0;
    localparam logic [1:0] SRC_VECT   = 2'd1;
    localparam logic [1:0] KIND_AWAY  = 2'd0;
    localparam logic [1:0] KIND_EVEN  = 2'd1;
    localparam logic [1:0] KIND_TRUNC = 2'd2;
    localparam logic [2:0] RM_LAST    = 3'd5;
endpackage

// File: rtl/rsat_shift_pick.sv
`timescale 1ns/1ps
// Chooses each lane's shift amount from a vector lane, a broadcast element
// or the immediate. It flags negative amounts (signed lanes only) and caps
// large amounts at ACC_W+1, so the lane rounder only sees 0..ACC_W+1.
// Assumes: LW >= IMM_W and LANES*LW == VEC_W.
module rsat_shift_pick #(
    parameter int VEC_W     = 64,
    parameter int LW        = 16,
    parameter int LANES     = 4,
    parameter int IMM_W     = 5,
    parameter int ACC_W     = 48,
    parameter int SH_W      = 6,
    parameter int SIGNED_SH = 1,
    parameter int IDX_W     = 2
) (
    input  logic [VEC_W-1:0]            shift_vec,
    input  logic [1:0]                  src_sel,
    input  logic [IDX_W-1:0]            elem_idx,
    input  logic [IMM_W-1:0]            imm,
    output logic [LANES-1:0][SH_W-1:0]  sh,
    output logic [LANES-1:0]            neg
);
    import rsat_pkg::*;

    localparam logic [LW-1:0] CAP = LW'(ACC_W + 1);

    logic [LW-1:0] elem_val;

    // Broadcast element selected by the index.
    always_comb elem_val = shift_vec[int'(elem_idx)*LW +: LW];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0]   raw;
        logic            neg_g;
        logic [SH_W-1:0] sh_g;

        // Per-lane source mux, sign test and range cap.
        always_comb begin
            case (src_sel)
                SRC_ELEM: raw = elem_val;
                SRC_VECT: raw = shift_vec[g*LW +: LW];
                default:  raw = LW'(imm);
            endcase
            neg_g = (SIGNED_SH != 0) && raw[LW-1];
            if (neg_g)           sh_g = '0;
            else if (raw > CAP)  sh_g = SH_W'(CAP);
            else                 sh_g = SH_W'(raw);
        end

        assign sh[g]  = sh_g;
        assign neg[g] = neg_g;
    end
endmodule

// File: rtl/rsat_lane.sv
`timescale 1ns/1ps
// One lane: shifts an accumulator right, rounds it by the mode code and
// saturates it to OUT_W bits. Also handles the out-of-range and exact-width
// shift cases.
// Assumes: sh is already capped to 0..ACC_W+1, and ACC_W+2 <= 64.
module rsat_lane #(
    parameter int ACC_W          = 48,
    parameter int OUT_W          = 16,
    parameter int SH_W           = 6,
    parameter int SIGNED_OK      = 1,
    parameter int EDGE_TRUNC_CMP = 1
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]  sh,
    input  logic [2:0]       rmode,
    output logic [OUT_W-1:0] res
);
    import rsat_pkg::*;

    localparam int XW = ACC_W + 2;
    localparam longint SMAX_L = (longint'(1) << (OUT_W-1)) - 1;
    localparam longint UMAX_L = (longint'(1) << OUT_W) - 1;
    localparam logic signed [XW-1:0] SMAX = XW'(SMAX_L);
    localparam logic signed [XW-1:0] SMIN = ~SMAX;
    localparam logic signed [XW-1:0] UMAX = XW'(UMAX_L);
    localparam logic [ACC_W-1:0] HALF_PT = ACC_W'(longint'(1) << (ACC_W-1));

    logic                 is_u, neg, half, sticky, inc, above_half;
    logic [1:0]           kind;
    int                   shn;
    logic signed [XW-1:0] wide, q, sum, clip;
    logic [XW-OUT_W-1:0]  unused_hi;

    // Extend, shift, and find the guard and sticky bits.
    always_comb begin
        is_u   = rmode[0];
        kind   = rmode[2:1];
        shn    = int'(sh);
        neg    = !is_u && acc[ACC_W-1];
        wide   = is_u ? $signed({2'b00, acc}) : $signed({{2{acc[ACC_W-1]}}, acc});
        q      = wide >>> sh;
        half   = 1'b0;
        sticky = 1'b0;
        for (int i = 0; i < ACC_W; i++) begin
            if (i + 1 == shn) half   = acc[i];
            if (i + 1 <  shn) sticky = sticky | acc[i];
        end
    end

    // Rounding increment chosen by the mode kind.
    always_comb begin
        case (kind)
            KIND_AWAY: inc = neg ? (half & sticky) : half;
            KIND_EVEN: inc = half & (sticky | q[0]);
            default:   inc = 1'b0;
        endcase
        sum = q + $signed({{(XW-1){1'b0}}, inc});
    end

    // Clamp: unsigned to all-ones; signed to the bound the sign bit picks.
    always_comb begin
        if (is_u)      clip = (sum > UMAX) ? UMAX : sum;
        else if (!neg) clip = (sum > SMAX) ? SMAX : sum;
        else           clip = (sum < SMIN) ? SMIN : sum;
        above_half = acc > HALF_PT;
        unused_hi  = clip[XW-1:OUT_W];
    end

    // Final select over reserved modes and shift range edges.
    always_comb begin
        if (kind == 2'd3)                       res = '0;
        else if (!is_u && SIGNED_OK == 0)       res = '0;
        else if (!is_u && shn >= ACC_W)         res = '0;
        else if (is_u && shn > ACC_W)           res = '0;
        else if (is_u && shn == ACC_W) begin
            case (kind)
                KIND_AWAY: res = OUT_W'(acc[ACC_W-1]);
                KIND_EVEN: res = OUT_W'(above_half);
                default:   res = (EDGE_TRUNC_CMP != 0) ? OUT_W'(above_half) : '0;
            endcase
        end
        else                                    res = clip[OUT_W-1:0];
    end
endmodule

// File: rtl/rsat_unit.sv
`timescale 1ns/1ps
// Top of the scale/round/saturate unit. Runs both lane formats in parallel,
// picks one by fmt, masks lanes with a negative shift, builds the
// unpredictable flag, and registers the packed result on in_valid.
// Assumes: both formats fill the same accumulator bus width.
module rsat_unit #(
    parameter int VEC_W     = 64,
    parameter int HW_W      = 16,
    parameter int HW_ACC_W  = 48,
    parameter int BY_W      = 8,
    parameter int BY_ACC_W  = 24,
    parameter int IMM_W     = 5,
    parameter int IDX_W     = $clog2(VEC_W / BY_W),
    parameter int ACC_BUS_W = (VEC_W / HW_W) * HW_ACC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 fmt,
    input  logic [2:0]           rmode,
    input  logic [1:0]           src_sel,
    input  logic [IDX_W-1:0]     elem_idx,
    input  logic [IMM_W-1:0]     shift_imm,
    input  logic [VEC_W-1:0]     shift_vec,
    input  logic [ACC_BUS_W-1:0] acc_in,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result,
    output logic                 unpred
);
    import rsat_pkg::*;

    localparam int HW_LANES = VEC_W / HW_W;
    localparam int BY_LANES = VEC_W / BY_W;
    localparam int HW_IDX_W = $clog2(HW_LANES);
    localparam int HW_SH_W  = $clog2(HW_ACC_W + 2);
    localparam int BY_SH_W  = $clog2(BY_ACC_W + 2);

    logic [HW_LANES-1:0][HW_SH_W-1:0] hw_sh;
    logic [HW_LANES-1:0]              hw_neg;
    logic [BY_LANES-1:0][BY_SH_W-1:0] by_sh;
    logic [BY_LANES-1:0]              by_neg_unused;
    logic [VEC_W-1:0]                 hw_word, by_word, res_d;
    logic                             unpred_d;

    rsat_shift_pick #(
        .VEC_W(VEC_W), .LW(HW_W), .LANES(HW_LANES), .IMM_W(IMM_W),
        .ACC_W(HW_ACC_W), .SH_W(HW_SH_W), .SIGNED_SH(1), .IDX_W(HW_IDX_W)
    ) u_hw_pick (
        .shift_vec(shift_vec), .src_sel(src_sel),
        .elem_idx(elem_idx[HW_IDX_W-1:0]), .imm(shift_imm),
        .sh(hw_sh), .neg(hw_neg)
    );

    rsat_shift_pick #(
        .VEC_W(VEC_W), .LW(BY_W), .LANES(BY_LANES), .IMM_W(IMM_W),
        .ACC_W(BY_ACC_W), .SH_W(BY_SH_W), .SIGNED_SH(0), .IDX_W(IDX_W)
    ) u_by_pick (
        .shift_vec(shift_vec), .src_sel(src_sel),
        .elem_idx(elem_idx), .imm(shift_imm),
        .sh(by_sh), .neg(by_neg_unused)
    );

    for (genvar g = 0; g < HW_LANES; g++) begin : g_hw
        logic [HW_W-1:0] lane_out;
        rsat_lane #(
            .ACC_W(HW_ACC_W), .OUT_W(HW_W), .SH_W(HW_SH_W),
            .SIGNED_OK(1), .EDGE_TRUNC_CMP(1)
        ) u_lane (
            .acc(acc_in[g*HW_ACC_W +: HW_ACC_W]), .sh(hw_sh[g]),
            .rmode(rmode), .res(lane_out)
        );
        assign hw_word[g*HW_W +: HW_W] = hw_neg[g] ? '0 : lane_out;
    end

    for (genvar g = 0; g < BY_LANES; g++) begin : g_by
        rsat_lane #(
            .ACC_W(BY_ACC_W), .OUT_W(BY_W), .SH_W(BY_SH_W),
            .SIGNED_OK(0), .EDGE_TRUNC_CMP(0)
        ) u_lane (
            .acc(acc_in[g*BY_ACC_W +: BY_ACC_W]), .sh(by_sh[g]),
            .rmode(rmode), .res(by_word[g*BY_W +: BY_W])
        );
    end

    // Format select and unpredictable-condition merge.
    always_comb begin
        res_d    = (fmt == FMT_HALF) ? hw_word : by_word;
        unpred_d = (rmode > RM_LAST)
                 || (fmt == FMT_BYTE && !rmode[0])
                 || (fmt == FMT_HALF && |hw_neg);
    end

    // Output register, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            unpred    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_d;
                unpred <= unpred_d;
            end
        end
    end

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(unpred));

    // R12
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (rmode > RM_LAST) |=> (result == '0) && unpred);

    // R12
    byte_signed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (fmt == FMT_BYTE) && !rmode[0] |=> (result == '0) && unpred);

    // R11
    imm_shift_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (src_sel[1]) && (rmode <= RM_LAST) && (fmt == FMT_HALF || rmode[0])
        |=> !unpred);

    for (genvar g = 0; g < HW_LANES; g++) begin : g_neg_chk
        // R11
        neg_shift_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (fmt == FMT_HALF) && (src_sel == SRC_VECT)
            && shift_vec[g*HW_W + HW_W - 1]
            |=> (result[g*HW_W +: HW_W] == '0) && unpred);
    end
endmodule

// File: tb/tb_rsat_unit.sv
`timescale 1ns/1ps
module tb_rsat_unit;
    logic         clk = 1'b0;
    logic         rst_n, in_valid, fmt;
    logic [2:0]   rmode;
    logic [1:0]   src_sel;
    logic [2:0]   elem_idx;
    logic [4:0]   shift_imm;
    logic [63:0]  shift_vec;
    logic [191:0] acc_in;
    logic         out_valid, unpred;
    logic [63:0]  result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rsat_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
        .rmode(rmode), .src_sel(src_sel), .elem_idx(elem_idx),
        .shift_imm(shift_imm), .shift_vec(shift_vec), .acc_in(acc_in),
        .out_valid(out_valid), .result(result), .unpred(unpred)
    );

    // Arithmetic model of one lane, written from the requirements.
    function automatic longint model(bit hw, int mode, longint raw, int s, output bit up);
        int A = hw ? 48 : 24;
        int W = hw ? 16 : 8;
        longint one = 1;
        longint m = (one << A) - 1;
        longint u = raw & m;
        longint sa = (u >= (one << (A-1))) ? u - (one << A) : u;
        longint t, smax, umax, hp;
        bit half = 0, sticky = 0;
        up = 0;
        if (mode > 5 || (!hw && mode % 2 == 0)) begin up = 1; return 0; end   // R12
        if (s < 0) begin up = 1; return 0; end                                 // R11
        if (s >= 1 && s <= A) half = ((u >> (s-1)) & 1) != 0;
        if (s >= 2 && s <= A) sticky = (u & ((one << (s-1)) - 1)) != 0;
        hp = one << (A-1);
        if (mode % 2 == 0) begin
            if (s >= 48) return 0;                                             // R9
            t = sa >>> s;
            if (mode == 0) t += (sa >= 0) ? longint'(half) : longint'(half && sticky);
            if (mode == 2 && half) t += sticky ? 1 : (t & 1);
            smax = (one << (W-1)) - 1;
            if (sa >= 0 && t > smax) t = smax;                                 // R7
            if (sa < 0 && t < -smax - 1) t = -smax - 1;
            return t & ((one << W) - 1);
        end
        if (s > A) return 0;
        if (s == A) begin                                                      // R10
            if (mode == 1) return u >> (A-1);
            if (mode == 3) return (u > hp) ? 1 : 0;
            return (hw && u > hp) ? 1 : 0;
        end
        t = u >> s;
        if (mode == 1) t += longint'(half);
        if (mode == 3 && half) t += sticky ? 1 : (t & 1);
        umax = (one << W) - 1;
        if (t > umax) t = umax;                                                // R8
        return t;
    endfunction

    function automatic string tag_of(bit hw, int mode, int s);
        int A = hw ? 48 : 24;
        if (mode > 5 || (!hw && mode % 2 == 0)) return "R12";
        if (s < 0) return "R11";
        if (s > A || (mode % 2 == 0 && s >= 48)) return "R9";
        if (s == A) return "R10";
        if (s == 0) return "R13";
        if (mode < 2) return "R5";
        if (mode < 4) return "R6";
        return "R4";
    endfunction

    function automatic int lane_shift(bit hw, int i);
        case (src_sel)
            2'd0: return hw ? int'($signed(shift_vec[16*elem_idx[1:0] +: 16]))
                            : int'(shift_vec[8*elem_idx +: 8]);
            2'd1: return hw ? int'($signed(shift_vec[16*i +: 16]))
                            : int'(shift_vec[8*i +: 8]);
            default: return int'(shift_imm);
        endcase
    endfunction

    function automatic longint lane_acc(bit hw, int i);
        return hw ? longint'(acc_in[48*i +: 48]) : longint'(acc_in[24*i +: 24]);
    endfunction

    // Apply the current inputs for one request and check every lane and the flag.
    task automatic run_vec(input string ftag);
        bit hw, up, up_any;
        longint e, got;
        int s;
        string tg;
        in_valid = 1'b1;
        @(negedge clk);
        hw = fmt;
        up_any = 0;
        for (int i = 0; i < (hw ? 4 : 8); i++) begin
            s   = lane_shift(hw, i);
            e   = model(hw, int'(rmode), lane_acc(hw, i), s, up);
            up_any |= up;
            got = hw ? longint'(result[16*i +: 16]) : longint'(result[8*i +: 8]);
            tg  = (ftag != "") ? ftag : tag_of(hw, int'(rmode), s);
            checks++;
            if (got != e) begin
                fails++;
                $display("FAIL %s lane %0d fmt=%0d mode=%0d shift=%0d: got %h expected %h",
                         tg, i, hw, rmode, s, got, e);
            end
        end
        checks++;
        if (unpred !== up_any || out_valid !== 1'b1) begin
            fails++;
            $display("FAIL %s flag fmt=%0d mode=%0d: got unpred=%0b valid=%0b expected %0b/1",
                     hw ? "R11" : "R12", hw, rmode, unpred, out_valid, up_any);
        end
    endtask

    task automatic fill_pattern(bit hw, int s, int pat);
        int A = hw ? 48 : 24;
        longint one = 1, k, half, off, v;
        for (int i = 0; i < (hw ? 4 : 8); i++) begin
            k    = hw ? longint'(i*5 + 1) : longint'(i + 1);
            half = (s > 0) ? (one << (s-1)) : 0;
            case (pat >> 1)
                0: off = 0;
                1: off = half;
                2: off = half + ((s > 1) ? 1 : 0);
                default: off = (half > 0) ? half - 1 : 0;
            endcase
            v = (k << s) + off;
            if (pat % 2 == 1) v = -v;
            v = v & ((one << A) - 1);
            if (hw) acc_in[48*i +: 48] = v[47:0];
            else    acc_in[24*i +: 24] = v[23:0];
        end
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] keep_r;
        logic        keep_u;
        rst_n = 1'b0; in_valid = 1'b0; fmt = 1'b0; rmode = '0; src_sel = '0;
        elem_idx = '0; shift_imm = '0; shift_vec = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || unpred !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got %0b %h %0b expected 0 0 0", out_valid, result, unpred);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Imm-shift sweep over formats, all modes, shifts and tie patterns (R4 R5 R6 R9 R12 R13).
        for (int f = 0; f < 2; f++)
            for (int m = 0; m < 8; m++)
                for (int s = 0; s < 32; s++)
                    for (int p = 0; p < 8; p++) begin
                        fmt = f[0]; rmode = m[2:0]; src_sel = 2'd2; shift_imm = s[4:0];
                        fill_pattern(f[0], s, p);
                        run_vec("");
                    end

        // Vector shifts at range edges and negatives (R9 R10 R11).
        for (int n = 0; n < 400; n++) begin
            bit hw = n[0];
            fmt = hw; rmode = 3'($urandom_range(0, 5)); src_sel = 2'd1;
            for (int i = 0; i < (hw ? 4 : 8); i++) begin
                int hs [10] = '{-1, -32768, 0, 1, 46, 47, 48, 49, 50, 300};
                int bs [7]  = '{0, 1, 22, 23, 24, 25, 200};
                logic [47:0] ha [5] = '{48'h8000_0000_0000, 48'h8000_0000_0001,
                                        48'h7FFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 48'h0};
                logic [23:0] ba [5] = '{24'h80_0000, 24'h80_0001, 24'h7F_FFFF,
                                        24'hFF_FFFF, 24'h0};
                int r = $urandom_range(0, 5);
                if (hw) begin
                    shift_vec[16*i +: 16] = 16'(hs[$urandom_range(0, 9)]);
                    acc_in[48*i +: 48] = (r == 5) ? {$urandom, $urandom} : ha[r];
                end else begin
                    shift_vec[8*i +: 8] = 8'(bs[$urandom_range(0, 6)]);
                    acc_in[24*i +: 24] = (r == 5) ? 24'($urandom) : ba[r];
                end
            end
            run_vec("");
        end

        // Broadcast element source (R3).
        for (int n = 0; n < 300; n++) begin
            fmt = n[0]; rmode = 3'($urandom_range(0, 7)); src_sel = 2'd0;
            elem_idx = 3'($urandom); shift_vec = {$urandom, $urandom} & 64'h1F1F_1F1F_1F1F_1F1F;
            acc_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_vec("R3");
        end

        // Saturation with small shifts on large accumulators (R7 R8).
        for (int n = 0; n < 300; n++) begin
            bit hw = n[0];
            fmt = hw; src_sel = 2'd1;
            rmode = hw ? 3'($urandom_range(0, 5)) : 3'(2*$urandom_range(0, 2) + 1);
            shift_vec = {$urandom, $urandom} & 64'h0007_0007_0007_0007;
            if (!hw) shift_vec = {$urandom, $urandom} & 64'h0707_0707_0707_0707;
            acc_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_vec(rmode[0] ? "R8" : "R7");
        end

        // Lane placement, distinct per-lane values (R2).
        fmt = 1'b0; rmode = 3'd5; src_sel = 2'd2; shift_imm = '0;
        for (int i = 0; i < 8; i++) acc_in[24*i +: 24] = 24'(i*17 + 3);
        run_vec("R2");
        fmt = 1'b1;
        for (int i = 0; i < 4; i++) acc_in[48*i +: 48] = 48'(i*4099 + 7);
        run_vec("R2");

        // Hold while idle (R1).
        keep_r = result; keep_u = unpred;
        in_valid = 1'b0; rmode = 3'd7; acc_in = ~acc_in;
        @(negedge clk); @(negedge clk);
        checks++;
        if (result !== keep_r || unpred !== keep_u || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 hold: got %h %0b %0b expected %h %0b 0",
                     result, unpred, out_valid, keep_r, keep_u);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule